// File: doc/BRIEF.md
# Double-Buffered Overlay Write Port with Transparent Merge

This block sits between a CPU write bus and two word-wide frame pages that hold an overlay layer. While one page is on screen, the CPU draws into the other one. A page-select bit in a control word decides which page is on screen, and every write is sent to the other page. The CPU gives a word address, 16 bits of data and an enable for each byte. It raises a strobe and watches a ready line. The block talks to each page through its own synchronous RAM port. Read data comes back one cycle after the read is issued.

A second control bit turns on transparency. In this mode, a data byte equal to zero means "keep what is there". Such a write needs a read-modify-write of the target word. The block reads the word, puts the stored bytes into the zero positions, and then writes the result back under the original byte enables. A write whose whole word is zero is dropped and touches nothing. The page and mode bits are captured when a request is accepted. Until that request finishes, the port refuses new work.

Top module: `fbw_merge_port`

## Requirements
- R1: After reset `wr_ready` is 1 and no page chip select is active.
- R2: A write goes to page 0 when control bit 5 is 1 and to page 1 when it is 0. The other page is left unchanged.
- R3: With transparency off (control bit 6 = 0), each byte whose enable is set is replaced by the matching data byte. `wr_be[0]` covers bits 7:0 and `wr_be[1]` covers bits 15:8. Bytes whose enable is clear keep their stored value.
- R4: A plain write holds `wr_ready` low for exactly one cycle, and in that cycle it issues one RAM write and no read.
- R5: A request with both byte enables clear, in either mode, finishes with no RAM access, and `wr_ready` stays 1.
- R6: With transparency on, a request whose data is 0x0000 issues no RAM access and leaves both pages unchanged.
- R7: With transparency on, a zero data byte is replaced by the stored byte at the same position before the word is written.
- R8: After the transparent merge, the byte enables still apply, so bytes whose enable is clear stay as stored.
- R9: A transparent write issues a read of the target word, then in the next cycle a write to the same page and address. `wr_ready` stays low for those two cycles.
- R10: The page and mode bits are taken at acceptance. Changing the control word while an operation is in progress does not change its target page or its merge behaviour.
- R11: A strobe raised while `wr_ready` is low is ignored, and its data reaches no page.
- R12: At most one page chip select is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | CTRL_W | Control word; bit 5 selects the displayed page, bit 6 turns on transparency |
| wr_req | input | 1 | Write strobe; the request is accepted when `wr_ready` is 1 |
| wr_addr | input | ADDR_W | Word address inside a page |
| wr_data | input | DATA_W | Write data |
| wr_be | input | DATA_W/8 | Byte enables, bit 0 for the low byte |
| wr_ready | output | 1 | 1 when idle and able to accept a request |
| ram_cs | output | 2 | Chip select for each page |
| ram_we | output | 2 | Write enable for each page (read when clear) |
| ram_be | output | 2*DATA_W/8 | Byte write enables for each page |
| ram_addr | output | 2*ADDR_W | Word address for each page |
| ram_wdata | output | 2*DATA_W | Write data for each page |
| ram_rdata | input | 2*DATA_W | Read data from each page, valid one cycle after a read |

## Verification
The bench sends a random mix of writes. Each data byte is zero about a third of the time, so in transparent mode some bytes merge and others overwrite. Writes with a single byte enable show whether the byte enables are applied after the merge or before it. All-zero words and all-zero enables are used to confirm that nothing is done. The page-select bit is flipped across the run, and both pages are checked after every write, which shows that each write lands on the correct page and the other page stays untouched. On some requests the bench flips the control bits while the operation is still running and raises a stray strobe with different data. This tests whether the mode and page were captured at acceptance and whether the busy port ignores the extra request.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } fbw_state_e;

  localparam int FBW_PAGES = 2;

endpackage

// File: rtl/fbw_req_latch.sv
module fbw_req_latch #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 16,
  parameter int CTRL_W    = 16,
  parameter int PAGE_BIT  = 5,
  parameter int TRANS_BIT = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [CTRL_W-1:0]     ctrl_word,
  input  logic [ADDR_W-1:0]     in_addr,
  input  logic [DATA_W-1:0]     in_data,
  input  logic [DATA_W/8-1:0]   in_be,
  output logic [ADDR_W-1:0]     q_addr,
  output logic [DATA_W-1:0]     q_data,
  output logic [DATA_W/8-1:0]   q_be,
  output logic                  q_page,
  output logic                  q_trans
);
  localparam int NB = DATA_W / 8;

  // Back page is the one not on screen: display bit high shows page 1.
  function automatic logic back_page(input logic [CTRL_W-1:0] c);
    return ~c[PAGE_BIT];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_addr  <= '0;
      q_data  <= '0;
      q_be    <= '0;
      q_page  <= 1'b0;
      q_trans <= 1'b0;
    end else if (load) begin
      q_addr  <= in_addr;
      q_data  <= in_data;
      q_be    <= in_be[NB-1:0];
      q_page  <= back_page(ctrl_word);
      q_trans <= ctrl_word[TRANS_BIT];
    end
  end
endmodule

// File: rtl/fbw_seq.sv
module fbw_seq
  import fbw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                trans_now,
  input  logic [DATA_W-1:0]   data,
  input  logic [DATA_W/8-1:0] be,
  output logic                ready,
  output logic                load,
  output logic                acc_drop,
  output logic                rd_phase,
  output logic                wr_phase
);
  fbw_state_e st, st_nx;
  logic accept, drop;

  // A request that cannot change memory retires in the accept cycle.
  function automatic logic is_void(input logic tr, input logic [DATA_W-1:0] d,
                                   input logic [DATA_W/8-1:0] e);
    return (e == '0) || (tr && (d == '0));
  endfunction

  always_comb begin
    accept   = req && (st == ST_IDLE);
    drop     = is_void(trans_now, data, be);
    load     = accept && !drop;
    acc_drop = accept && drop;
    st_nx    = st;
    unique case (st)
      ST_IDLE:  if (load) st_nx = trans_now ? ST_READ : ST_WRITE;
      ST_READ:  st_nx = ST_WRITE;
      ST_WRITE: st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign ready    = (st == ST_IDLE);
  assign rd_phase = (st == ST_READ);
  assign wr_phase = (st == ST_WRITE);
endmodule

// File: rtl/fbw_lane_merge.sv
module fbw_lane_merge #(
  parameter int DATA_W = 16
) (
  input  logic              trans,
  input  logic [DATA_W-1:0] new_word,
  input  logic [DATA_W-1:0] old_word,
  output logic [DATA_W-1:0] merged
);
  localparam int NB = DATA_W / 8;

  function automatic logic [7:0] pick(input logic tr, input logic [7:0] n, input logic [7:0] o);
    return (tr && (n == 8'h00)) ? o : n;
  endfunction

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign merged[b*8 +: 8] = pick(trans, new_word[b*8 +: 8], old_word[b*8 +: 8]);
  end
endmodule

// File: rtl/fbw_page_drive.sv
module fbw_page_drive #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  parameter int NPAGE  = 2
) (
  input  logic                      rd_phase,
  input  logic                      wr_phase,
  input  logic                      page,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [DATA_W/8-1:0]       be,
  output logic [NPAGE-1:0]          ram_cs,
  output logic [NPAGE-1:0]          ram_we,
  output logic [NPAGE*DATA_W/8-1:0] ram_be,
  output logic [NPAGE*ADDR_W-1:0]   ram_addr,
  output logic [NPAGE*DATA_W-1:0]   ram_wdata
);
  localparam int NB = DATA_W / 8;

  for (genvar p = 0; p < NPAGE; p++) begin : g_page
    logic hit;
    assign hit                        = (int'(page) == p);
    assign ram_cs[p]                  = hit && (rd_phase || wr_phase);
    assign ram_we[p]                  = hit && wr_phase;
    assign ram_be[p*NB +: NB]         = (hit && wr_phase) ? be : '0;
    assign ram_addr[p*ADDR_W +: ADDR_W] = addr;
    assign ram_wdata[p*DATA_W +: DATA_W] = wdata;
  end
endmodule

// File: rtl/fbw_merge_port.sv
module fbw_merge_port
  import fbw_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 16,
  parameter int CTRL_W    = 16,
  parameter int PAGE_BIT  = 5,
  parameter int TRANS_BIT = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CTRL_W-1:0]             ctrl_word,
  input  logic                          wr_req,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [DATA_W/8-1:0]           wr_be,
  output logic                          wr_ready,
  output logic [FBW_PAGES-1:0]          ram_cs,
  output logic [FBW_PAGES-1:0]          ram_we,
  output logic [FBW_PAGES*DATA_W/8-1:0] ram_be,
  output logic [FBW_PAGES*ADDR_W-1:0]   ram_addr,
  output logic [FBW_PAGES*DATA_W-1:0]   ram_wdata,
  input  logic [FBW_PAGES*DATA_W-1:0]   ram_rdata
);
  localparam int NB    = DATA_W / 8;
  localparam int NPAGE = FBW_PAGES;

  // Event wires brought out for the checker.
  logic load, acc_drop, rd_phase, wr_phase;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_data, old_word, merged;
  logic [NB-1:0]     q_be;
  logic              q_page, q_trans;
  logic              unused_ctrl;

  assign unused_ctrl = ^ctrl_word;

  function automatic logic [DATA_W-1:0] page_word(input logic [NPAGE*DATA_W-1:0] bus,
                                                  input logic pg);
    return bus[int'(pg)*DATA_W +: DATA_W];
  endfunction

  fbw_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(wr_req), .trans_now(ctrl_word[TRANS_BIT]),
    .data(wr_data), .be(wr_be), .ready(wr_ready), .load(load),
    .acc_drop(acc_drop), .rd_phase(rd_phase), .wr_phase(wr_phase)
  );

  fbw_req_latch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W),
    .PAGE_BIT(PAGE_BIT), .TRANS_BIT(TRANS_BIT)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .load(load), .ctrl_word(ctrl_word),
    .in_addr(wr_addr), .in_data(wr_data), .in_be(wr_be),
    .q_addr(q_addr), .q_data(q_data), .q_be(q_be), .q_page(q_page), .q_trans(q_trans)
  );

  assign old_word = page_word(ram_rdata, q_page);

  fbw_lane_merge #(.DATA_W(DATA_W)) u_merge (
    .trans(q_trans), .new_word(q_data), .old_word(old_word), .merged(merged)
  );

  fbw_page_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPAGE(NPAGE)) u_drive (
    .rd_phase(rd_phase), .wr_phase(wr_phase), .page(q_page), .addr(q_addr),
    .wdata(merged), .be(q_be), .ram_cs(ram_cs), .ram_we(ram_we), .ram_be(ram_be),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );
endmodule

// File: rtl/fbw_merge_port_chk.sv
module fbw_merge_port_chk #(
  parameter int ADDR_W = 15,
  parameter int NPAGE  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_ready,
  input logic [NPAGE-1:0]        ram_cs,
  input logic [NPAGE-1:0]        ram_we,
  input logic [NPAGE*ADDR_W-1:0] ram_addr,
  input logic                    load,
  input logic                    acc_drop
);
  logic rd_any, wr_any;
  assign rd_any = |(ram_cs & ~ram_we);
  assign wr_any = |(ram_cs & ram_we);

  a_r12_single_page: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ram_cs));

  a_r4_busy_while_access: assert property (@(posedge clk) disable iff (!rst_n)
    (|ram_cs) |-> !wr_ready);

  a_r4_accept_starts_access: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!wr_ready && (|ram_cs)));

  a_r9_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> (wr_any && $stable(ram_cs)));

  a_r9_same_address: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> $stable(ram_addr));

  a_r6_drop_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    acc_drop |=> (ram_cs == '0) && wr_ready);
endmodule

bind fbw_merge_port fbw_merge_port_chk #(.ADDR_W(ADDR_W), .NPAGE(FBW_PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .ram_cs(ram_cs), .ram_we(ram_we),
  .ram_addr(ram_addr), .load(load), .acc_drop(acc_drop)
);

// File: tb/fbw_merge_port_tb.sv
module fbw_merge_port_tb_top;
  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   ctrl_word = '0;
  logic          wr_req = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    wr_be = '0;
  logic          wr_ready;
  logic [1:0]    ram_cs, ram_we;
  logic [3:0]    ram_be;
  logic [2*AW-1:0] ram_addr;
  logic [2*DW-1:0] ram_wdata, ram_rdata;

  int n_cmp = 0, n_bad = 0;
  int cs_cycles = 0, both_cs = 0;

  logic [15:0] mem [2][DEPTH];
  logic [15:0] shadow [2][DEPTH];
  logic [15:0] rdq [2];

  always #5 clk = ~clk;

  fbw_merge_port #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .wr_ready(wr_ready),
    .ram_cs(ram_cs), .ram_we(ram_we), .ram_be(ram_be), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // Bench-owned page memories, one-cycle read latency.
  always @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (ram_cs[p]) begin
        if (ram_we[p]) begin
          if (ram_be[p*2])   mem[p][ram_addr[p*AW +: AW]][7:0]  <= ram_wdata[p*DW +: 8];
          if (ram_be[p*2+1]) mem[p][ram_addr[p*AW +: AW]][15:8] <= ram_wdata[p*DW+8 +: 8];
        end else begin
          rdq[p] <= mem[p][ram_addr[p*AW +: AW]];
        end
      end
    end
  end
  assign ram_rdata = {rdq[1], rdq[0]};

  always @(negedge clk) begin
    if (rst_n && (ram_cs != 2'b00)) cs_cycles++;
    if (ram_cs == 2'b11) both_cs++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_word(input logic [15:0] old, input logic [15:0] d,
                                             input logic [1:0] be, input logic tr);
    logic [7:0] lo, hi;
    if (tr && d == 16'h0000) return old;
    lo = d[7:0];
    hi = d[15:8];
    if (tr) begin
      if (lo == 8'h00) lo = old[7:0];
      if (hi == 8'h00) hi = old[15:8];
    end
    return {be[1] ? hi : old[15:8], be[0] ? lo : old[7:0]};
  endfunction

  function automatic int model_busy(input logic [15:0] d, input logic [1:0] be, input logic tr);
    if (be == 2'b00) return 0;
    if (tr && d == 16'h0000) return 0;
    return tr ? 2 : 1;
  endfunction

  task automatic do_op(input string tag, input logic [AW-1:0] a, input logic [15:0] d,
                       input logic [1:0] be, input logic pg_bit, input logic tr,
                       input bit meddle);
    int tgt, busy, exp_busy, cs0;
    logic [15:0] saved_ctrl;
    logic [15:0] before_other;
    tgt = pg_bit ? 0 : 1;
    exp_busy = model_busy(d, be, tr);
    before_other = shadow[1-tgt][a];
    @(negedge clk);
    ctrl_word = 16'h0000;
    ctrl_word[5] = pg_bit;
    ctrl_word[6] = tr;
    saved_ctrl = ctrl_word;
    wr_addr = a; wr_data = d; wr_be = be; wr_req = 1'b1;
    cs0 = cs_cycles;
    @(posedge clk);
    @(negedge clk);
    busy = 0;
    if (meddle && exp_busy > 0) begin
      // R10 / R11: flip mode and page, raise a stray request with other data
      ctrl_word = saved_ctrl ^ 16'h0060;
      wr_data = ~d; wr_be = 2'b11; wr_req = 1'b1;
    end else begin
      wr_req = 1'b0;
    end
    while (!wr_ready && busy < 10) begin
      busy++;
      @(negedge clk);
      wr_req = 1'b0;
    end
    ctrl_word = saved_ctrl;
    shadow[tgt][a] = model_word(shadow[tgt][a], d, be, tr);
    check({tag, " target page word"}, {16'h0, mem[tgt][a]}, {16'h0, shadow[tgt][a]});
    check({tag, " R2 other page untouched"}, {16'h0, mem[1-tgt][a]}, {16'h0, before_other});
    check({tag, " ready-low cycles"}, busy, exp_busy);
    check({tag, " RAM access cycles"}, cs_cycles - cs0, exp_busy);
  endtask

  initial begin
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < DEPTH; i++) begin
        mem[p][i]    = 16'((i * 16'h3b17) ^ (p * 16'h5a00) ^ 16'h0c30);
        shadow[p][i] = mem[p][i];
      end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [15:0] d;
    logic [1:0]  be;
    void'($urandom(32'h1d5e7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 ready after reset", wr_ready, 1'b1);
    check("R1 no chip select in reset", ram_cs, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready idle", wr_ready, 1'b1);

    do_op("R2 R3 R4 bit5=1 plain", 8'h10, 16'hbeef, 2'b11, 1'b1, 1'b0, 0);
    do_op("R2 R3 R4 bit5=0 plain", 8'h10, 16'h1234, 2'b11, 1'b0, 1'b0, 0);
    do_op("R3 low byte only", 8'h11, 16'h00a5, 2'b01, 1'b1, 1'b0, 0);
    do_op("R3 high byte only zero data", 8'h12, 16'h0000, 2'b10, 1'b0, 1'b0, 0);
    do_op("R5 plain no enables", 8'h13, 16'hffff, 2'b00, 1'b1, 1'b0, 0);
    do_op("R5 transparent no enables", 8'h14, 16'h4321, 2'b00, 1'b0, 1'b1, 0);
    do_op("R6 transparent zero word", 8'h15, 16'h0000, 2'b11, 1'b1, 1'b1, 0);
    do_op("R7 R9 zero high byte kept", 8'h16, 16'h00ab, 2'b11, 1'b0, 1'b1, 0);
    do_op("R7 R9 zero low byte kept", 8'h17, 16'hcd00, 2'b11, 1'b1, 1'b1, 0);
    do_op("R8 enables after merge", 8'h18, 16'h1234, 2'b10, 1'b0, 1'b1, 0);
    do_op("R8 merged lane disabled", 8'h19, 16'h0056, 2'b10, 1'b1, 1'b1, 0);
    do_op("R10 R11 plain with meddling", 8'h1a, 16'h7777, 2'b11, 1'b1, 1'b0, 1);
    do_op("R10 R11 transparent with meddling", 8'h1b, 16'h0099, 2'b11, 1'b0, 1'b1, 1);

    for (int k = 0; k < 400; k++) begin
      d[7:0]  = ($urandom_range(2) == 0) ? 8'h00 : 8'($urandom);
      d[15:8] = ($urandom_range(2) == 0) ? 8'h00 : 8'($urandom);
      be = 2'($urandom);
      do_op("R3 R7 R8 random", 8'($urandom), d, be, 1'($urandom), 1'($urandom),
            ($urandom_range(3) == 0));
    end

    check("R12 both pages never selected", both_cs, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule